// File: doc/BRIEF.md
# Packet Page Allocation Unit

This block manages a shared pool of buffer pages for a network controller. Each page is named by a packet number. Transmit and receive draw from the same pool, with no fixed split between them. A host issues one command per cycle: allocate a page, release a packet, enqueue a packet for transmission, or clear the transmit queues. The unit keeps a bitmap of free pages and reports how many remain. On allocation it returns the lowest free page number together with a failure flag.

A failed allocation does not go away. It stays pending, and it is granted without further host action as soon as a page becomes free. Two queues of packet numbers are kept. The transmit queue feeds the transmitter. The completion queue holds packets whose transmission has finished. When automatic release is enabled, a packet that transmits successfully goes back to the pool and never enters the completion queue.

Top module: `pkt_page_mgr`

## Requirements
- R1: After reset, every page is free (`free_cnt` = NPAGE), `alloc_fail` is 0 and both queues are empty.
- R2: An allocate command (op 1) with at least one free page returns the lowest-numbered free page on `alloc_pkt`, clears `alloc_fail` and lowers `free_cnt` by one. These results appear on the clock edge that takes the command.
- R3: An allocate command with no free page sets `alloc_fail`. The flag stays set for as long as no page is free. One edge after a free page first shows in `free_cnt`, the pending request is granted: `alloc_pkt` takes the lowest free page and `alloc_fail` clears.
- R4: A release command (op 2) on an allocated page frees it and raises `free_cnt` by one. A release command on a page that is already free is ignored: `free_cnt` does not change.
- R5: An enqueue command (op 3) appends `cmd_pkt` to the transmit queue. `txq_head` shows the oldest entry, and `txq_empty` is 0 while any entry is queued. Entries leave in arrival order.
- R6: A transmit-done pulse (`tx_done`) removes the head of the transmit queue. When automatic release is off, that packet is appended to the completion queue, which shows its oldest entry on `cmp_head`. `cmp_pop` removes that oldest entry.
- R7: When `auto_rel` is 1 and `tx_ok` is 1, the completed packet's page is returned to the pool and the completion queue is left unchanged. When `tx_ok` is 0, the packet goes to the completion queue even with `auto_rel` set.
- R8: A queue-reset command (op 4) empties both queues and frees no page: `free_cnt` is unchanged.
- R9: The pool has no transmit/receive partition. All NPAGE pages can be allocated one after another without a failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | 1 allocate, 2 release, 3 enqueue, 4 clear queues |
| cmd_pkt | input | PW | Packet number for release or enqueue |
| auto_rel | input | 1 | Free packets automatically on successful transmit |
| tx_done | input | 1 | Transmitter finished the packet at the queue head |
| tx_ok | input | 1 | That transmission succeeded |
| cmp_pop | input | 1 | Remove the oldest completion entry |
| alloc_pkt | output | PW | Last granted packet number |
| alloc_fail | output | 1 | Allocation failed and is still pending |
| free_cnt | output | CW | Number of free pages |
| txq_head | output | PW | Packet number at the transmit queue output |
| txq_empty | output | 1 | Transmit queue empty |
| cmp_head | output | PW | Oldest completion queue entry |
| cmp_empty | output | 1 | Completion queue empty |

## Verification
Commands, transmit-done pulses and pops are sampled on the same edge that updates every output. The bench therefore drives each stimulus on a falling edge and checks the result on the next falling edge. The one exception is a pending allocation, which needs two edges: the first edge registers the freed page, and the second grants it. The bench checks `alloc_fail` after the first edge, while it must still be set, and again after the second edge, when it must be clear.

// File: rtl/pkt_page_mgr.sv
module pkt_page_mgr #(
  parameter int NPAGE = 32,
  parameter int PW = $clog2(NPAGE),
  parameter int CW = $clog2(NPAGE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [PW-1:0] cmd_pkt,
  input  logic          auto_rel,
  input  logic          tx_done,
  input  logic          tx_ok,
  input  logic          cmp_pop,
  output logic [PW-1:0] alloc_pkt,
  output logic          alloc_fail,
  output logic [CW-1:0] free_cnt,
  output logic [PW-1:0] txq_head,
  output logic          txq_empty,
  output logic [PW-1:0] cmp_head,
  output logic          cmp_empty
);
  localparam logic [2:0] OP_ALLOC = 3'd1;
  localparam logic [2:0] OP_REL   = 3'd2;
  localparam logic [2:0] OP_ENQ   = 3'd3;
  localparam logic [2:0] OP_CLRQ  = 3'd4;
  localparam logic [CW-1:0] FULL  = CW'(NPAGE);

  logic [NPAGE-1:0] free_map, grant_mask, rel_mask;
  logic             pend, any_free;
  logic [PW-1:0]    low_free;

  logic [PW-1:0] tx_mem [NPAGE];
  logic [PW-1:0] cp_mem [NPAGE];
  logic [PW-1:0] tx_rd, tx_wr, cp_rd, cp_wr;
  logic [CW-1:0] tx_cnt, cp_cnt;

  wire is_alloc  = cmd_valid && cmd_op == OP_ALLOC;
  wire is_rel    = cmd_valid && cmd_op == OP_REL;
  wire is_enq    = cmd_valid && cmd_op == OP_ENQ;
  wire is_clr    = cmd_valid && cmd_op == OP_CLRQ;
  wire do_alloc  = is_alloc || pend;
  wire tx_pop    = tx_done && tx_cnt != '0;
  wire auto_free = tx_pop && auto_rel && tx_ok;
  wire tx_push   = is_enq && tx_cnt != FULL;
  wire cp_push   = tx_pop && !auto_free && cp_cnt != FULL;
  wire cp_take   = cmp_pop && cp_cnt != '0;

  assign any_free  = |free_map;
  assign txq_head  = tx_mem[tx_rd];
  assign cmp_head  = cp_mem[cp_rd];
  assign txq_empty = tx_cnt == '0;
  assign cmp_empty = cp_cnt == '0;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(NPAGE - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    low_free = '0;
    for (int i = NPAGE - 1; i >= 0; i--)
      if (free_map[i]) low_free = PW'(i);
  end

  always_comb begin
    free_cnt = '0;
    for (int i = 0; i < NPAGE; i++)
      free_cnt = free_cnt + CW'(free_map[i]);
  end

  always_comb begin
    grant_mask = '0;
    rel_mask   = '0;
    if (do_alloc && any_free) grant_mask[low_free] = 1'b1;
    if (is_rel) rel_mask[cmd_pkt] = 1'b1;
    if (auto_free) rel_mask[txq_head] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_map   <= '1;
      pend       <= 1'b0;
      alloc_fail <= 1'b0;
      alloc_pkt  <= '0;
    end else begin
      free_map <= (free_map | rel_mask) & ~grant_mask;
      if (do_alloc) begin
        if (any_free) begin
          alloc_pkt  <= low_free;
          alloc_fail <= 1'b0;
          pend       <= 1'b0;
        end else begin
          alloc_fail <= 1'b1;
          pend       <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wr] <= cmd_pkt;
    if (cp_push) cp_mem[cp_wr] <= txq_head;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || is_clr) begin
      tx_rd  <= '0;
      tx_wr  <= '0;
      tx_cnt <= '0;
      cp_rd  <= '0;
      cp_wr  <= '0;
      cp_cnt <= '0;
    end else begin
      if (tx_push) tx_wr <= nxt(tx_wr);
      if (tx_pop)  tx_rd <= nxt(tx_rd);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
      if (cp_push) cp_wr <= nxt(cp_wr);
      if (cp_take) cp_rd <= nxt(cp_rd);
      cp_cnt <= cp_cnt + CW'(cp_push) - CW'(cp_take);
    end
  end

  p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= FULL);

  p_grant_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (do_alloc && any_free) |=> (!alloc_fail && !free_map[alloc_pkt]));

  p_fail_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_fail && !any_free) |=> alloc_fail);

  p_fail_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && any_free) |=> !alloc_fail);

  p_rel_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rel && free_map[cmd_pkt] && !do_alloc && !auto_free) |=> $stable(free_cnt));

  p_clear_queues_r8: assert property (@(posedge clk) disable iff (!rst_n)
    is_clr |=> (txq_empty && cmp_empty));

  p_auto_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_free && !cp_take && !is_clr) |=> $stable(cp_cnt));
endmodule

// File: tb/sim_pkt_page_mgr.sv
module sim_pkt_page_mgr;
  localparam int NPAGE = 32;
  localparam int PW = 5;
  localparam int CW = 6;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, auto_rel = 0, tx_done = 0, tx_ok = 0, cmp_pop = 0;
  logic [2:0] cmd_op = 0;
  logic [PW-1:0] cmd_pkt = 0;
  logic [PW-1:0] alloc_pkt, txq_head, cmp_head;
  logic alloc_fail, txq_empty, cmp_empty;
  logic [CW-1:0] free_cnt;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  pkt_page_mgr #(.NPAGE(NPAGE)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_pkt(cmd_pkt), .auto_rel(auto_rel), .tx_done(tx_done), .tx_ok(tx_ok),
    .cmp_pop(cmp_pop), .alloc_pkt(alloc_pkt), .alloc_fail(alloc_fail),
    .free_cnt(free_cnt), .txq_head(txq_head), .txq_empty(txq_empty),
    .cmp_head(cmp_head), .cmp_empty(cmp_empty));

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cmd(input logic [2:0] op, input int pkt);
    cmd_valid = 1; cmd_op = op; cmd_pkt = PW'(pkt);
    step();
    cmd_valid = 0; cmd_op = 0;
  endtask

  task automatic done(input logic ok);
    tx_done = 1; tx_ok = ok;
    step();
    tx_done = 0; tx_ok = 0;
  endtask

  task automatic t_reset();
    chk(free_cnt, NPAGE, "R1 free_cnt");
    chk(alloc_fail, 0, "R1 alloc_fail");
    chk(txq_empty, 1, "R1 txq_empty");
    chk(cmp_empty, 1, "R1 cmp_empty");
  endtask

  task automatic t_alloc_release();
    cmd(3'd1, 0);
    chk(alloc_pkt, 0, "R2 first grant");
    chk(free_cnt, NPAGE-1, "R2 count");
    cmd(3'd1, 0);
    chk(alloc_pkt, 1, "R2 second grant");
    chk(alloc_fail, 0, "R2 no fail");
    cmd(3'd2, 0);
    chk(free_cnt, NPAGE-1, "R4 release");
    cmd(3'd2, 0);
    chk(free_cnt, NPAGE-1, "R4 double release ignored");
    cmd(3'd2, 9);
    chk(free_cnt, NPAGE-1, "R4 release of free page ignored");
    cmd(3'd1, 0);
    chk(alloc_pkt, 0, "R2 lowest reused");
  endtask

  task automatic t_exhaust();
    int bad = 0;
    for (int i = 2; i < NPAGE; i++) begin
      cmd(3'd1, 0);
      if (alloc_fail !== 1'b0 || alloc_pkt !== PW'(i)) bad++;
    end
    chk(bad, 0, "R9 every page grantable");
    chk(free_cnt, 0, "R9 pool empty");
    cmd(3'd1, 0);
    chk(alloc_fail, 1, "R3 fail set");
    step(); step();
    chk(alloc_fail, 1, "R3 fail held");
    cmd(3'd2, 7);
    chk(alloc_fail, 1, "R3 fail until grant edge");
    step();
    chk(alloc_fail, 0, "R3 pending granted");
    chk(alloc_pkt, 7, "R3 granted page");
    chk(free_cnt, 0, "R3 count after grant");
    for (int i = 0; i < NPAGE; i++) cmd(3'd2, i);
    chk(free_cnt, NPAGE, "R4 all released");
  endtask

  task automatic t_queues();
    cmd(3'd1, 0); cmd(3'd1, 0); cmd(3'd1, 0);
    cmd(3'd3, 2); cmd(3'd3, 0); cmd(3'd3, 1);
    chk(txq_empty, 0, "R5 not empty");
    chk(txq_head, 2, "R5 head oldest");
    auto_rel = 0;
    done(1);
    chk(txq_head, 0, "R5 order");
    chk(cmp_empty, 0, "R6 completion filled");
    chk(cmp_head, 2, "R6 completion head");
    done(1);
    chk(txq_head, 1, "R6 tx head advanced");
    chk(cmp_head, 2, "R6 completion order");
    cmp_pop = 1; step(); cmp_pop = 0;
    chk(cmp_head, 0, "R6 pop");
    chk(free_cnt, NPAGE-3, "R6 no free without auto");
  endtask

  task automatic t_auto();
    auto_rel = 1;
    done(1);
    chk(free_cnt, NPAGE-2, "R7 auto freed");
    chk(txq_empty, 1, "R7 tx drained");
    chk(cmp_head, 0, "R7 completion untouched");
    cmp_pop = 1; step(); cmp_pop = 0;
    chk(cmp_empty, 1, "R7 completion one entry only");
    cmd(3'd3, 2);
    done(0);
    chk(cmp_empty, 0, "R7 failed tx queued");
    chk(cmp_head, 2, "R7 failed pkt");
    chk(free_cnt, NPAGE-2, "R7 failed tx not freed");
    auto_rel = 0;
  endtask

  task automatic t_clear();
    cmd(3'd3, 0); cmd(3'd3, 2);
    cmd(3'd4, 0);
    chk(txq_empty, 1, "R8 tx cleared");
    chk(cmp_empty, 1, "R8 completion cleared");
    chk(free_cnt, NPAGE-2, "R8 nothing freed");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_alloc_release();
    t_exhaust();
    t_queues();
    t_auto();
    t_clear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule